// File: doc/BRIEF.md
# Software-Driven Serial Configuration Loader

This block is the host-facing port through which software loads configuration data into a programmable logic device one bit at a time. The host owns a single 16-bit register at subaddress 0x00 of its own function. It raises and lowers a clock bit and sets a data bit. The block turns those writes into a clean serial stream on three device pins: an active-low clear, a configuration clock and a configuration data line. The device reports back through a ready (status) line and a done line. Both are brought into the clock domain through a two-flop synchronizer.

The block is built around a five-state sequencer. CLEARED holds the device clear line low. ARMED has clear released and clock low. SETUP means a clock rise is pending for one cycle after a data change. CLKHI has the configuration clock high. CONFIGURED means done has been seen. The transitions are as follows. Any write with the clear bit at 0 moves any state to CLEARED. A write with the clear bit at 1 moves CLEARED to ARMED. From ARMED, a clock-rise write goes to SETUP when the data bit changes in the same write, and straight to CLKHI when it does not. SETUP moves to CLKHI after one cycle, or back to ARMED if a write drops the clock bit. CLKHI returns to ARMED on a write with the clock bit at 0. ARMED and CLKHI move to CONFIGURED when the synchronized done is seen.

Until CONFIGURED is reached, the block holds the main controller function in reset and refuses its register accesses. A sticky violation flag records any attempt to clock a bit while the device is cleared or not ready.

Top module: `cfg_loader_port`

## Requirements
- R1: Register read layout: bit 3 returns the clock bit, bit 2 the data bit, bit 1 the synchronized status and bit 0 done. Bit 4 (clear, write-only) and bits [15:5] read as 0.
- R2: After reset, and on the cycle after any write with bit 4 = 0, dev_clear_n is 0, dev_cclk is 0, done reads 0 and load_viol is 0. This applies from every state.
- R3: A write with bit 4 = 1 drives dev_clear_n to 1 from the next cycle. dev_clear_n stays 1 until a write with bit 4 = 0.
- R4: A write that takes the clock bit (bit 3) from 0 to 1 produces a rising dev_cclk only when clear was already 1 before the write and the synchronized status is 1. Otherwise dev_cclk stays 0.
- R5: dev_cdata follows the written data bit (bit 2). When a clock-rise write also changes the data bit, dev_cdata changes on the next cycle and dev_cclk rises one cycle after that. When the data bit is unchanged, dev_cclk rises on the next cycle.
- R6: While a clock rise is pending or dev_cclk is high, the data bit of a write that keeps bit 3 = 1 is ignored. A write with bit 3 = 0 during a pending rise cancels the rise and loads its data bit.
- R7: The status bit reads dev_status delayed by two clock cycles.
- R8: Done reads 1 once the synchronized dev_done is seen while loading, and stays 1 until a clear write. While done is 1, dev_cclk is held at 0 and clock writes have no effect.
- R9: main_rst_hold is 1 and main_acc_ok is 0 until done. After done, main_rst_hold is 0 and main_acc_ok follows main_acc.
- R10: load_viol is set by a rejected clock-rise write and stays set through later writes. Only a clear write or reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one write per high cycle |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read value |
| dev_status | input | 1 | Device ready to accept configuration bits |
| dev_done | input | 1 | Device configuration complete |
| dev_clear_n | output | 1 | Active-low device configuration clear |
| dev_cclk | output | 1 | Configuration clock |
| dev_cdata | output | 1 | Configuration data |
| load_viol | output | 1 | Sticky flag for a rejected clock attempt |
| main_acc | input | 1 | Access request to the main controller function |
| main_acc_ok | output | 1 | Access request accepted as valid |
| main_rst_hold | output | 1 | Reset hold for the main controller function |

## Verification
The hardest states to reach are the single-cycle SETUP state and the writes that land inside it. A stimulus that issues one write and then idles always finds SETUP already gone. The bench therefore has a back-to-back write task. Its first write changes the data bit and raises the clock, and its second write arrives in the very next cycle, either dropping the clock to cancel the rise or keeping it high with a different data bit that must be ignored. The not-ready case is reached by holding the device model busy while the loader is armed. A full load is then finished with violation still flagged, which shows the flag is sticky.

// File: rtl/clp_pkg.sv
package clp_pkg;

    typedef enum logic [2:0] {
        LD_CLEARED    = 3'd0,
        LD_ARMED      = 3'd1,
        LD_SETUP      = 3'd2,
        LD_CLKHI      = 3'd3,
        LD_CONFIGURED = 3'd4
    } ld_state_t;

    localparam int unsigned REG_WIDTH = 16;
    localparam int unsigned CLR_BIT   = 4;
    localparam int unsigned CLK_BIT   = 3;
    localparam int unsigned DAT_BIT   = 2;
    localparam int unsigned STA_BIT   = 1;
    localparam int unsigned DONE_BIT  = 0;

endpackage

// File: rtl/clp_sync.sv
module clp_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [STAGES-1:0][WIDTH-1:0] stg_q;

    generate
        if (STAGES > 1) begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stg_q <= '0;
                end else begin
                    stg_q <= {stg_q[STAGES-2:0], din};
                end
            end
        end else begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stg_q <= '0;
                end else begin
                    stg_q[0] <= din;
                end
            end
        end
    endgenerate

    assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/clp_seq_fsm.sv
module clp_seq_fsm
    import clp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr,
    input  logic wr_clr,
    input  logic wr_clk,
    input  logic wr_dat,
    input  logic sts,
    input  logic dne,
    output logic clr_q,
    output logic clk_q,
    output logic data_q,
    output logic done_q,
    output logic viol_q
);

    ld_state_t st_q, st_nx;
    logic      clear_wr, set_wr, rise_req, hold_data, data_nx, viol_set;

    always_comb begin
        clear_wr  = wr && !wr_clr;
        set_wr    = wr && wr_clr;
        rise_req  = set_wr && wr_clk;
        hold_data = (st_q == LD_SETUP || st_q == LD_CLKHI) && wr_clk && !clear_wr;
        data_nx   = (wr && !hold_data) ? wr_dat : data_q;
        viol_set  = rise_req &&
                    ((st_q == LD_CLEARED) || (st_q == LD_ARMED && !dne && !sts));

        st_nx = st_q;
        if (clear_wr) begin
            st_nx = LD_CLEARED;
        end else begin
            unique case (st_q)
                LD_CLEARED: begin
                    if (set_wr) st_nx = LD_ARMED;
                end
                LD_ARMED: begin
                    if (dne) begin
                        st_nx = LD_CONFIGURED;
                    end else if (rise_req && sts) begin
                        st_nx = (wr_dat != data_q) ? LD_SETUP : LD_CLKHI;
                    end
                end
                LD_SETUP: begin
                    st_nx = (set_wr && !wr_clk) ? LD_ARMED : LD_CLKHI;
                end
                LD_CLKHI: begin
                    if (dne) begin
                        st_nx = LD_CONFIGURED;
                    end else if (set_wr && !wr_clk) begin
                        st_nx = LD_ARMED;
                    end
                end
                LD_CONFIGURED: begin
                    st_nx = LD_CONFIGURED;
                end
                default: st_nx = LD_CLEARED;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= LD_CLEARED;
        end else begin
            st_q <= st_nx;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clr_q  <= 1'b0;
            clk_q  <= 1'b0;
            data_q <= 1'b0;
            done_q <= 1'b0;
            viol_q <= 1'b0;
        end else begin
            clr_q  <= (st_nx != LD_CLEARED);
            clk_q  <= (st_nx == LD_CLKHI);
            data_q <= data_nx;
            done_q <= (st_nx == LD_CONFIGURED);
            viol_q <= clear_wr ? 1'b0 : (viol_q || viol_set);
        end
    end

    AST_RISE_NEEDS_CLEAR_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_q) |-> clr_q && $past(clr_q)); // R4

    AST_DATA_SETTLED_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_q) |-> $stable(data_q)); // R5

    AST_DATA_HELD_WHILE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_q && $past(clk_q)) |-> $stable(data_q)); // R6

    AST_CLEAR_WRITE_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr && !wr_clr) |-> (!clr_q && !clk_q && !viol_q && !done_q)); // R2

    AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(viol_q) && !$past(wr && !wr_clr)) |-> viol_q); // R10

    AST_DONE_CLOCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(done_q) && done_q) |-> !clk_q); // R8

endmodule

// File: rtl/clp_readback.sv
module clp_readback
    import clp_pkg::*;
#(
    parameter int unsigned REG_W = REG_WIDTH
) (
    input  logic             clk_bit,
    input  logic             dat_bit,
    input  logic             sts_bit,
    input  logic             done_bit,
    output logic [REG_W-1:0] rdata
);

    always_comb begin
        rdata           = '0;
        rdata[CLK_BIT]  = clk_bit;
        rdata[DAT_BIT]  = dat_bit;
        rdata[STA_BIT]  = sts_bit;
        rdata[DONE_BIT] = done_bit;
    end

endmodule

// File: rtl/clp_gate.sv
module clp_gate (
    input  logic cfg_done,
    input  logic acc_req,
    output logic acc_ok,
    output logic rst_hold
);

    assign acc_ok   = acc_req && cfg_done;
    assign rst_hold = !cfg_done;

endmodule

// File: rtl/cfg_loader_port.sv
module cfg_loader_port
    import clp_pkg::*;
#(
    parameter int unsigned REG_W       = REG_WIDTH,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             dev_status,
    input  logic             dev_done,
    output logic             dev_clear_n,
    output logic             dev_cclk,
    output logic             dev_cdata,
    output logic             load_viol,
    input  logic             main_acc,
    output logic             main_acc_ok,
    output logic             main_rst_hold
);

    logic [1:0] sync_out;
    logic       done_q;
    logic       unused_wbits;

    assign unused_wbits = ^{reg_wdata[REG_W-1:CLR_BIT+1], reg_wdata[STA_BIT:DONE_BIT]};

    clp_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({dev_status, dev_done}),
        .dout  (sync_out)
    );

    clp_seq_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (reg_wr),
        .wr_clr (reg_wdata[CLR_BIT]),
        .wr_clk (reg_wdata[CLK_BIT]),
        .wr_dat (reg_wdata[DAT_BIT]),
        .sts    (sync_out[1]),
        .dne    (sync_out[0]),
        .clr_q  (dev_clear_n),
        .clk_q  (dev_cclk),
        .data_q (dev_cdata),
        .done_q (done_q),
        .viol_q (load_viol)
    );

    clp_readback #(.REG_W(REG_W)) u_rb (
        .clk_bit  (dev_cclk),
        .dat_bit  (dev_cdata),
        .sts_bit  (sync_out[1]),
        .done_bit (done_q),
        .rdata    (reg_rdata)
    );

    clp_gate u_gate (
        .cfg_done (done_q),
        .acc_req  (main_acc),
        .acc_ok   (main_acc_ok),
        .rst_hold (main_rst_hold)
    );

endmodule

// File: tb/cfg_loader_port_bench.sv
`timescale 1ns/1ps
module cfg_loader_port_bench;

    localparam int NBITS = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        dev_status = 1'b0;
    logic        dev_done = 1'b0;
    logic        dev_clear_n, dev_cclk, dev_cdata, load_viol;
    logic        main_acc = 1'b0;
    logic        main_acc_ok, main_rst_hold;

    int checks = 0;
    int fails  = 0;

    // device model state
    int          dv_cnt = 0;
    logic [31:0] dv_shift = '0;
    logic        dv_prev = 1'b0;
    logic        dv_busy = 1'b0;

    // reference model state (state codes: 0 cleared, 1 armed, 2 pending, 3 high, 4 configured)
    int   m_st = 0;
    logic m_data = 0, m_viol = 0;
    logic m_s1 = 0, m_s2 = 0, m_d1 = 0, m_d2 = 0;

    always #2 clk = ~clk;

    cfg_loader_port u_cfg_loader_port (
        .clk           (clk),
        .rst_n         (rst_n),
        .reg_wr        (reg_wr),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .dev_status    (dev_status),
        .dev_done      (dev_done),
        .dev_clear_n   (dev_clear_n),
        .dev_cclk      (dev_cclk),
        .dev_cdata     (dev_cdata),
        .load_viol     (load_viol),
        .main_acc      (main_acc),
        .main_acc_ok   (main_acc_ok),
        .main_rst_hold (main_rst_hold)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // reference model, advanced on every rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_data = 0; m_viol = 0;
            m_s1 = 0; m_s2 = 0; m_d1 = 0; m_d2 = 0;
        end else begin
            logic w, c, k, d, vset;
            int   nst;
            w = reg_wr; c = reg_wdata[4]; k = reg_wdata[3]; d = reg_wdata[2];
            nst = m_st;
            if (w && !c) nst = 0;
            else begin
                case (m_st)
                    0: if (w) nst = 1;
                    1: if (m_d2) nst = 4;
                       else if (w && k && m_s2) nst = (d != m_data) ? 2 : 3;
                    2: nst = (w && !k) ? 1 : 3;
                    3: if (m_d2) nst = 4; else if (w && !k) nst = 1;
                    default: ;
                endcase
            end
            vset = w && c && k && (m_st == 0 || (m_st == 1 && !m_d2 && !m_s2));
            if (w && !c) m_viol = 0; else if (vset) m_viol = 1;
            if (w && (!c || !((m_st == 2 || m_st == 3) && k))) m_data = d;
            m_st = nst;
            m_s2 = m_s1; m_s1 = dev_status;
            m_d2 = m_d1; m_d1 = dev_done;
        end
    end

    // per-cycle comparison, then device model update
    always begin
        @(negedge clk);
        #1;
        if (rst_n) begin
            chk("R1 upper bits zero", {20'd0, reg_rdata[15:4]}, 32'd0);
            chk("R1 clock/data readback", reg_rdata[3:2], {m_st == 3, m_data});
            chk("R3 clear line", dev_clear_n, m_st != 0);
            chk("R4 clock line", dev_cclk, m_st == 3);
            chk("R5 data line", dev_cdata, m_data);
            chk("R7 status readback", reg_rdata[1], m_s2);
            chk("R8 done readback", reg_rdata[0], m_st == 4);
            chk("R9 reset hold", main_rst_hold, m_st != 4);
            chk("R9 access gate", main_acc_ok, main_acc && (m_st == 4));
            chk("R10 violation flag", load_viol, m_viol);
        end
        if (!dev_clear_n) begin
            dv_cnt = 0; dv_shift = '0;
        end else if (dev_cclk && !dv_prev && dev_status) begin
            dv_shift = {dv_shift[30:0], dev_cdata};
            dv_cnt++;
        end
        dv_prev    = dev_cclk;
        dev_done   = dev_clear_n && (dv_cnt >= NBITS);
        dev_status = dev_clear_n && !dv_busy && !dev_done;
    end

    task automatic reg_write(input logic [15:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
        #1;
    endtask

    task automatic reg_write2(input logic [15:0] v1, input logic [15:0] v2);
        @(negedge clk);
        reg_wr = 1'b1; reg_wdata = v1;
        @(negedge clk);
        reg_wdata = v2;
        @(negedge clk);
        reg_wr = 1'b0;
        #1;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    // data set first, then clock rise, then fall
    task automatic bit_split(input logic b);
        reg_write(16'h0010 | (16'(b) << 2));
        reg_write(16'h0018 | (16'(b) << 2));
        reg_write(16'h0010 | (16'(b) << 2));
    endtask

    // data and clock rise in one write, then fall
    task automatic bit_joined(input logic b);
        reg_write(16'h0018 | (16'(b) << 2));
        idle(1);
        reg_write(16'h0010 | (16'(b) << 2));
    endtask

    initial begin
        logic [11:0] pat_a;
        logic [10:0] pat_b;
        pat_a = 12'hA5C;
        pat_b = 11'h3C9;
        idle(3);
        rst_n = 1'b1;
        idle(1);
        chk("R1 reset read value", reg_rdata, 16'h0000);
        chk("R2 reset clear low", dev_clear_n, 1'b0);
        chk("R9 reset hold high", main_rst_hold, 1'b1);

        // clock attempt while cleared
        reg_write(16'h0018);
        chk("R10 rise from cleared flagged", load_viol, 1'b1);
        chk("R4 rise from cleared ignored", dev_cclk, 1'b0);
        reg_write(16'h0000);
        chk("R2 clear write drops flag", load_viol, 1'b0);

        // load pattern A with separate data and clock writes
        reg_write(16'h0010);
        idle(4);
        chk("R7 status seen after arm", reg_rdata[1], 1'b1);
        for (int i = NBITS - 1; i >= 0; i--) bit_split(pat_a[i]);
        idle(6);
        chk("R8 done after full load", reg_rdata[0], 1'b1);
        chk("R4 device captured pattern A", dv_shift[11:0], pat_a);
        main_acc = 1'b1;
        idle(1);
        chk("R9 access valid after done", main_acc_ok, 1'b1);
        reg_write(16'h0018);
        chk("R8 clock write ignored when done", dev_cclk, 1'b0);
        main_acc = 1'b0;

        // clear wipes done
        reg_write(16'h0000);
        chk("R2 clear write drops done", reg_rdata[0], 1'b0);
        chk("R9 hold back after clear", main_rst_hold, 1'b1);

        // not-ready device: rise rejected
        dv_busy = 1'b1;
        reg_write(16'h0010);
        idle(4);
        reg_write(16'h0018);
        chk("R4 rise while not ready ignored", dev_cclk, 1'b0);
        chk("R10 rise while not ready flagged", load_viol, 1'b1);
        reg_write(16'h0010);
        dv_busy = 1'b0;
        idle(4);

        // pending rise cancelled by clock-low write
        reg_write2(16'h001C, 16'h0010);
        chk("R6 cancelled rise keeps clock low", dev_cclk, 1'b0);
        chk("R6 cancelling write loads data", dev_cdata, 1'b0);
        chk("R4 no bit clocked by cancelled rise", dv_cnt, 0);

        // data of a write during a pending rise is ignored
        reg_write2(16'h001C, 16'h0018);
        chk("R6 clock high after pending rise", dev_cclk, 1'b1);
        chk("R6 data held through pending rise", dev_cdata, 1'b1);
        reg_write(16'h0014);
        for (int i = 10; i >= 0; i--) bit_joined(pat_b[i]);
        idle(6);
        chk("R8 done after second load", reg_rdata[0], 1'b1);
        chk("R5 device captured pattern B", dv_shift[11:0], {1'b1, pat_b});
        chk("R10 flag survived the load", load_viol, 1'b1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #800000;
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule